// File: doc/BRIEF.md
# Capture/Reload Timer-Counter (16-bit)

This block is a 16-bit up-counter that hangs off a byte-wide microcontroller register bus. Software sees five byte registers: a control byte, the two bytes of the running count and the two bytes of a capture/reload pair. The counter advances either once per core clock or once per falling edge on an external count pin. When it passes all-ones it either reloads from the capture/reload pair or wraps to zero, depending on the mode. A falling edge on a separate trigger pin can latch the running count into the capture/reload pair or force an early reload.

A baud mode is chosen through either of two serial-clock select bits. In that mode the counter always reloads on overflow, the overflow flag stays clear and the trigger pin no longer captures or reloads. Each overflow is driven out as a one-cycle pulse on the receive and/or transmit baud-tick output, so a serial port can take its bit clock from this timer. Both status flags are sticky, are cleared only by software, and are also driven out as interrupt request lines.

Both pins pass through a synchronizer before edge detection. Every hardware update yields to a bus write that targets the same byte or flag in the same cycle. The control byte can also be changed one bit at a time through a separate bit-write port.

Top module: `tmr16_top`

## Requirements
- R1: After reset, every register reads 00h and the four outputs `ovf_irq`, `ext_irq`, `rx_baud_tick` and `tx_baud_tick` are low.
- R2: Byte addresses: control C8h, count low CCh, count high CDh, capture/reload low CAh, capture/reload high CBh. A bus write takes effect at the next clock edge and reads are combinational. Any other address reads 00h and a write to it has no effect. Control bits, from 7 down to 0: overflow flag, trigger flag, receive-baud select, transmit-baud select, trigger enable, run, pin-count select, capture select.
- R3: With run = 1 and pin-count select = 0, the count rises by one on every clock edge. With run = 0 the count holds its value.
- R4: With run = 1 and pin-count select = 1, the count rises by exactly one for each falling edge on `cnt_pin`. The new value is visible after the third rising clock edge that follows the fall of the pin.
- R5: When the count steps past FFFFh it loads the capture/reload pair if capture select = 0, and it wraps to 0000h if capture select = 1. Outside baud mode the overflow flag is set in both cases.
- R6: With capture select = 1, trigger enable = 1 and both baud selects = 0, a falling edge on `trig_pin` copies the count into the capture/reload pair. The copied value is the count before any increment in that same cycle. The trigger flag is set. The edge acts on the third clock edge after the pin falls.
- R7: With capture select = 0, trigger enable = 1 and both baud selects = 0, a falling edge on `trig_pin` loads the capture/reload pair into the count and sets the trigger flag.
- R8: With trigger enable = 0, a falling edge on `trig_pin` changes neither the count, nor the capture/reload pair, nor the trigger flag.
- R9: When either baud select is 1, the counter reloads on overflow whatever capture select holds, and the overflow flag is not set. Each overflow gives a one-cycle high pulse on `rx_baud_tick` (receive select) and/or `tx_baud_tick` (transmit select) in the cycle after the overflow edge. A trigger edge with trigger enable = 1 sets only the trigger flag.
- R10: Both flags stay set until software clears them. `ovf_irq` follows the overflow flag and `ext_irq` follows the trigger flag.
- R11: If a bus write to a count byte, a capture/reload byte or the control byte falls in the same cycle as a hardware update of that byte or flag, the written value wins.
- R12: A bit write (`bit_we` = 1) sets control bit `bit_idx` to `bit_val` and leaves the other seven bits as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_we | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| bit_we | input | 1 | Single-bit write strobe for the control byte |
| bit_idx | input | 3 | Control bit chosen by a bit write |
| bit_val | input | 1 | Value written by a bit write |
| cnt_pin | input | 1 | External count input, active on falling edges |
| trig_pin | input | 1 | External capture/reload trigger, active on falling edges |
| ovf_irq | output | 1 | Overflow interrupt request (overflow flag) |
| ext_irq | output | 1 | Trigger interrupt request (trigger flag) |
| rx_baud_tick | output | 1 | Overflow pulse for the serial receive clock |
| tx_baud_tick | output | 1 | Overflow pulse for the serial transmit clock |

## Verification
The risky coincidence is a trigger capture landing on the same clock edge as a count overflow in capture mode. The bench starts the counter at FFFDh and drops the trigger pin just after the control write, so the edge detector fires exactly on the FFFFh-to-0000h step. That case passes only if the capture/reload pair reads FFFFh, the count has wrapped and moved on to 0001h, and both flags and both interrupt lines are set. A second coincidence, a bus write landing on a counting edge or on an overflow that would set the flag, is judged by whether the written byte and the cleared flag come through untouched.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  localparam int BYTE_W    = 8;
  localparam int CNT_BYTES = 2;
  localparam int CNT_W     = BYTE_W * CNT_BYTES;
  localparam int IDX_W     = $clog2(BYTE_W);

  // Register byte addresses (software-visible map)
  localparam logic [BYTE_W-1:0] ADDR_CTRL   = 8'hC8;
  localparam logic [BYTE_W-1:0] ADDR_RLD_LO = 8'hCA;
  localparam logic [BYTE_W-1:0] ADDR_RLD_HI = 8'hCB;
  localparam logic [BYTE_W-1:0] ADDR_CNT_LO = 8'hCC;
  localparam logic [BYTE_W-1:0] ADDR_CNT_HI = 8'hCD;

  // Flag bit positions inside the control byte
  localparam logic [IDX_W-1:0] IDX_OVF = 3'd7;
  localparam logic [IDX_W-1:0] IDX_EXT = 3'd6;

  // Control byte, MSB first
  typedef struct packed {
    logic ovf_flag;
    logic ext_flag;
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic run;
    logic cnt_sel;
    logic cap_sel;
  } tmr_ctrl_t;

endpackage

// File: rtl/tmr16_edge_sync.sv
module tmr16_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  // One event per sampled high-to-low step
  assign fall_o = last_q & ~sync_q[STAGES-1];

  assert_single_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o)
    else $error("edge detector produced two events for one fall");

endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic             bit_we_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             bit_val_i,
  input  logic             ovf_set_i,
  input  logic             ext_set_i,
  output tmr_ctrl_t        ctrl_o
);

  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] ctrl_nxt;
  logic              sw_owns_ovf;
  logic              sw_owns_ext;

  // Software write to a flag bit wins over the hardware set
  assign sw_owns_ovf = byte_we_i | (bit_we_i && bit_idx_i == IDX_OVF);
  assign sw_owns_ext = byte_we_i | (bit_we_i && bit_idx_i == IDX_EXT);

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (byte_we_i) ctrl_nxt = wdata_i;
    if (bit_we_i)  ctrl_nxt[bit_idx_i] = bit_val_i;
    if (ovf_set_i && !sw_owns_ovf) ctrl_nxt[IDX_OVF] = 1'b1;
    if (ext_set_i && !sw_owns_ext) ctrl_nxt[IDX_EXT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_nxt;
  end

  assign ctrl_o = tmr_ctrl_t'(ctrl_q);

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[IDX_OVF] && !sw_owns_ovf) |=> ctrl_q[IDX_OVF])
    else $error("overflow flag cleared without software");

  assert_ext_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[IDX_EXT] && !sw_owns_ext) |=> ctrl_q[IDX_EXT])
    else $error("trigger flag cleared without software");

  assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set_i && !sw_owns_ovf) |=> ctrl_q[IDX_OVF])
    else $error("overflow did not set the flag");

  assert_bit_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we_i && !byte_we_i && !ovf_set_i && !ext_set_i) |=>
      (ctrl_q[$past(bit_idx_i)] == $past(bit_val_i)))
    else $error("bit write did not land");

  assert_byte_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we_i && !bit_we_i) |=> ctrl_q == $past(wdata_i))
    else $error("control byte write lost to hardware");

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_i,
  input  logic                 cnt_sel_i,
  input  logic                 cap_sel_i,
  input  logic                 ext_en_i,
  input  logic                 baud_i,
  input  logic                 cnt_fall_i,
  input  logic                 trig_fall_i,
  input  logic [CNT_BYTES-1:0] cnt_we_i,
  input  logic [CNT_BYTES-1:0] rld_we_i,
  input  logic [BYTE_W-1:0]    wdata_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [CNT_W-1:0]     rld_o,
  output logic                 ovf_evt_o,
  output logic                 trig_evt_o
);

  logic [CNT_W-1:0] cnt_q, rld_q;
  logic [CNT_W-1:0] cnt_hw, rld_hw;
  logic [CNT_W-1:0] cnt_nxt, rld_nxt;

  // Named internal events
  logic inc_evt;
  logic reload_mode;
  logic cap_evt;
  logic trig_rld_evt;
  logic load_evt;

  function automatic logic [CNT_W-1:0] f_advance(
    input logic [CNT_W-1:0] cur,
    input logic             step_en,
    input logic             load,
    input logic [CNT_W-1:0] ld_val
  );
    if (load)    return ld_val;
    if (step_en) return cur + {{(CNT_W-1){1'b0}}, 1'b1};
    return cur;
  endfunction

  function automatic logic f_at_top(input logic [CNT_W-1:0] cur);
    return &cur;
  endfunction

  // Replace the bytes flagged in mask with the bus data
  function automatic logic [CNT_W-1:0] f_lane_merge(
    input logic [CNT_W-1:0]     hw,
    input logic [CNT_BYTES-1:0] mask,
    input logic [BYTE_W-1:0]    data
  );
    logic [CNT_W-1:0] res;
    res = hw;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (mask[b]) res[b*BYTE_W +: BYTE_W] = data;
    end
    return res;
  endfunction

  assign inc_evt      = run_i & (cnt_sel_i ? cnt_fall_i : 1'b1);
  assign ovf_evt_o    = inc_evt & f_at_top(cnt_q);
  assign reload_mode  = baud_i | ~cap_sel_i;
  assign trig_evt_o   = trig_fall_i & ext_en_i;
  assign cap_evt      = trig_evt_o &  cap_sel_i & ~baud_i;
  assign trig_rld_evt = trig_evt_o & ~cap_sel_i & ~baud_i;
  assign load_evt     = trig_rld_evt | (ovf_evt_o & reload_mode);

  always_comb begin
    cnt_hw  = f_advance(cnt_q, inc_evt, load_evt, rld_q);
    rld_hw  = cap_evt ? cnt_q : rld_q;
    cnt_nxt = f_lane_merge(cnt_hw, cnt_we_i, wdata_i);
    rld_nxt = f_lane_merge(rld_hw, rld_we_i, wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      rld_q <= rld_nxt;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !trig_rld_evt && cnt_we_i == '0) |=> $stable(cnt_q))
    else $error("count moved while stopped");

  assert_reload_on_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt_o && reload_mode && cnt_we_i == '0) |=> cnt_q == $past(rld_q))
    else $error("overflow in reload mode did not load the pair");

  assert_wrap_on_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt_o && !reload_mode && !trig_rld_evt && cnt_we_i == '0) |=> cnt_q == '0)
    else $error("overflow in capture mode did not wrap");

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && rld_we_i == '0) |=> rld_q == $past(cnt_q))
    else $error("capture missed the count");

  assert_trig_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_rld_evt && cnt_we_i == '0) |=> cnt_q == $past(rld_q))
    else $error("trigger reload missed");

  assert_no_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en_i && rld_we_i == '0) |=> $stable(rld_q))
    else $error("pair changed with trigger disabled");

  assert_baud_no_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_i && rld_we_i == '0) |=> $stable(rld_q))
    else $error("pair changed in baud mode");

  assert_cnt_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i[0] |=> cnt_q[BYTE_W-1:0] == $past(wdata_i))
    else $error("count byte write lost to hardware");

endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        bit_we,
  input  logic [2:0]  bit_idx,
  input  logic        bit_val,
  input  logic        cnt_pin,
  input  logic        trig_pin,
  output logic        ovf_irq,
  output logic        ext_irq,
  output logic        rx_baud_tick,
  output logic        tx_baud_tick
);

  localparam int N_PINS = 2;
  localparam int PIN_CNT  = 0;
  localparam int PIN_TRIG = 1;

  tmr_ctrl_t             ctrl;
  logic [CNT_W-1:0]      cnt, rld;
  logic [N_PINS-1:0]     pins_in, pin_fall;
  logic [CNT_BYTES-1:0]  cnt_we, rld_we;
  logic                  ctrl_we;
  logic                  baud_mode;
  logic                  ovf_evt, trig_evt;
  logic                  ovf_set;
  logic                  rx_tick_q, tx_tick_q;

  assign pins_in = {trig_pin, cnt_pin};

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    tmr16_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pins_in[g]),
      .fall_o (pin_fall[g])
    );
  end

  // Write decode
  assign ctrl_we   = bus_we && bus_addr == ADDR_CTRL;
  assign cnt_we[0] = bus_we && bus_addr == ADDR_CNT_LO;
  assign cnt_we[1] = bus_we && bus_addr == ADDR_CNT_HI;
  assign rld_we[0] = bus_we && bus_addr == ADDR_RLD_LO;
  assign rld_we[1] = bus_we && bus_addr == ADDR_RLD_HI;

  assign baud_mode = ctrl.rx_sel | ctrl.tx_sel;
  assign ovf_set   = ovf_evt & ~baud_mode;

  tmr16_core u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (ctrl.run),
    .cnt_sel_i   (ctrl.cnt_sel),
    .cap_sel_i   (ctrl.cap_sel),
    .ext_en_i    (ctrl.ext_en),
    .baud_i      (baud_mode),
    .cnt_fall_i  (pin_fall[PIN_CNT]),
    .trig_fall_i (pin_fall[PIN_TRIG]),
    .cnt_we_i    (cnt_we),
    .rld_we_i    (rld_we),
    .wdata_i     (bus_wdata),
    .cnt_o       (cnt),
    .rld_o       (rld),
    .ovf_evt_o   (ovf_evt),
    .trig_evt_o  (trig_evt)
  );

  tmr16_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_we_i (ctrl_we),
    .wdata_i   (bus_wdata),
    .bit_we_i  (bit_we),
    .bit_idx_i (bit_idx),
    .bit_val_i (bit_val),
    .ovf_set_i (ovf_set),
    .ext_set_i (trig_evt),
    .ctrl_o    (ctrl)
  );

  // Baud pulses: one cycle after each overflow edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_tick_q <= 1'b0;
      tx_tick_q <= 1'b0;
    end else begin
      rx_tick_q <= ovf_evt & ctrl.rx_sel;
      tx_tick_q <= ovf_evt & ctrl.tx_sel;
    end
  end

  assign rx_baud_tick = rx_tick_q;
  assign tx_baud_tick = tx_tick_q;
  assign ovf_irq      = ctrl.ovf_flag;
  assign ext_irq      = ctrl.ext_flag;

  always_comb begin
    case (bus_addr)
      ADDR_CTRL:   bus_rdata = ctrl;
      ADDR_CNT_LO: bus_rdata = cnt[BYTE_W-1:0];
      ADDR_CNT_HI: bus_rdata = cnt[CNT_W-1:BYTE_W];
      ADDR_RLD_LO: bus_rdata = rld[BYTE_W-1:0];
      ADDR_RLD_HI: bus_rdata = rld[CNT_W-1:BYTE_W];
      default:     bus_rdata = '0;
    endcase
  end

  assert_rx_tick_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && ctrl.rx_sel) |=> rx_baud_tick)
    else $error("receive tick missing after overflow");

  assert_tx_tick_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_evt && ctrl.tx_sel) |=> !tx_baud_tick)
    else $error("transmit tick without overflow");

  assert_baud_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && baud_mode && !ctrl.ovf_flag && !ctrl_we && !bit_we) |=> !ovf_irq)
    else $error("overflow flag set in baud mode");

  assert_irq_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_irq == bus_rdata[7]) || bus_addr != ADDR_CTRL)
    else $error("interrupt line disagrees with flag");

endmodule

// File: tb/tmr16_top_tb.sv
module tmr16_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       bit_we = 1'b0;
  logic [2:0] bit_idx = 3'd0;
  logic       bit_val = 1'b0;
  logic       cnt_pin = 1'b1;
  logic       trig_pin = 1'b1;
  logic       ovf_irq, ext_irq, rx_baud_tick, tx_baud_tick;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    bit         pins;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t exp_q[$];
  bit    probe = 1'b0;

  always #4 clk = ~clk;

  tmr16_top u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bit_we       (bit_we),
    .bit_idx      (bit_idx),
    .bit_val      (bit_val),
    .cnt_pin      (cnt_pin),
    .trig_pin     (trig_pin),
    .ovf_irq      (ovf_irq),
    .ext_irq      (ext_irq),
    .rx_baud_tick (rx_baud_tick),
    .tx_baud_tick (tx_baud_tick)
  );

  // Monitor: pops one expected item per probed cycle
  always @(negedge clk) begin
    item_t      it;
    logic [7:0] act;
    if (probe) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty actual=none expected=item");
      end else begin
        it  = exp_q.pop_front();
        act = it.pins ? {4'b0, rx_baud_tick, tx_baud_tick, ext_irq, ovf_irq} : bus_rdata;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic bwr(input logic [2:0] idx, input logic v);
    bit_idx = idx; bit_val = v; bit_we = 1'b1;
    step();
    bit_we = 1'b0;
  endtask

  // Driver: pushes the expectation, monitor compares this cycle
  task automatic chk_reg(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.pins = 1'b0; it.exp = e; it.tag = tag;
    bus_addr = a;
    exp_q.push_back(it);
    probe = 1'b1;
    step();
    probe = 1'b0;
  endtask

  // e = {rx_tick, tx_tick, ext_irq, ovf_irq}
  task automatic chk_pins(input logic [3:0] e, input string tag);
    item_t it;
    it.pins = 1'b1; it.exp = {4'b0, e}; it.tag = tag;
    exp_q.push_back(it);
    probe = 1'b1;
    step();
    probe = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;

    // R1 reset state
    chk_reg(8'hC8, 8'h00, "R1 control after reset");
    chk_reg(8'hCC, 8'h00, "R1 count low after reset");
    chk_reg(8'hCB, 8'h00, "R1 pair high after reset");
    chk_pins(4'b0000, "R1 outputs after reset");

    // R2 map and readback
    wr(8'hCA, 8'h34); wr(8'hCB, 8'h12);
    wr(8'hCC, 8'h78); wr(8'hCD, 8'h56);
    wr(8'hC9, 8'hAA);
    chk_reg(8'hCA, 8'h34, "R2 pair low");
    chk_reg(8'hCB, 8'h12, "R2 pair high");
    chk_reg(8'hCC, 8'h78, "R2 count low");
    chk_reg(8'hCD, 8'h56, "R2 count high");
    chk_reg(8'hC9, 8'h00, "R2 unmapped read");
    chk_reg(8'hC8, 8'h00, "R2 unmapped write ignored");

    // R3 timer mode: 11 edges with run set
    wr(8'hCC, 8'hF0); wr(8'hCD, 8'h00);
    wr(8'hC8, 8'h04);
    idle(10);
    wr(8'hC8, 8'h00);
    chk_reg(8'hCC, 8'hFB, "R3 count after eleven ticks");
    idle(5);
    chk_reg(8'hCC, 8'hFB, "R3 count holds when stopped");

    // R5 auto-reload overflow, R12 bit write, R10 sticky flag
    wr(8'hCC, 8'hFE); wr(8'hCD, 8'hFF);
    wr(8'hC8, 8'h04);
    idle(1);
    bwr(3'd2, 1'b0);
    chk_pins(4'b0001, "R10 overflow interrupt line");
    chk_reg(8'hC8, 8'h80, "R5 overflow flag R12 run cleared");
    chk_reg(8'hCC, 8'h34, "R5 reload low");
    chk_reg(8'hCD, 8'h12, "R5 reload high");
    idle(3);
    chk_reg(8'hC8, 8'h80, "R10 flag sticky");
    bwr(3'd3, 1'b1);
    chk_reg(8'hC8, 8'h88, "R12 single bit set");
    bwr(3'd7, 1'b0);
    bwr(3'd3, 1'b0);
    chk_reg(8'hC8, 8'h00, "R12 flag cleared by bit write");
    chk_pins(4'b0000, "R10 interrupt dropped");

    // R5 capture mode wrap
    wr(8'hCC, 8'hFF); wr(8'hCD, 8'hFF);
    wr(8'hC8, 8'h05);
    bwr(3'd2, 1'b0);
    chk_reg(8'hCC, 8'h00, "R5 wrap low");
    chk_reg(8'hCD, 8'h00, "R5 wrap high");
    chk_reg(8'hCA, 8'h34, "R5 pair untouched on wrap");
    chk_reg(8'hC8, 8'h81, "R5 flag in capture mode");
    wr(8'hC8, 8'h00);

    // R4 pin counting
    wr(8'hCC, 8'h10); wr(8'hCD, 8'h00);
    wr(8'hC8, 8'h06);
    cnt_pin = 1'b0;
    idle(2);
    chk_reg(8'hCC, 8'h10, "R4 no change before third edge");
    chk_reg(8'hCC, 8'h11, "R4 one count after third edge");
    cnt_pin = 1'b1; idle(4);
    cnt_pin = 1'b0; idle(4);
    cnt_pin = 1'b1; idle(4);
    cnt_pin = 1'b0; idle(4);
    cnt_pin = 1'b1; idle(4);
    chk_reg(8'hCC, 8'h13, "R4 one count per fall");
    wr(8'hC8, 8'h00);

    // R6 capture by trigger while counting
    wr(8'hCC, 8'h00); wr(8'hCD, 8'h01);
    wr(8'hC8, 8'h0D);
    trig_pin = 1'b0;
    idle(3);
    bwr(3'd2, 1'b0);
    chk_pins(4'b0010, "R6 trigger interrupt");
    chk_reg(8'hCA, 8'h02, "R6 captured low");
    chk_reg(8'hCB, 8'h01, "R6 captured high");
    chk_reg(8'hCC, 8'h04, "R6 count kept running");
    chk_reg(8'hC8, 8'h49, "R6 trigger flag");
    trig_pin = 1'b1; idle(4);

    // R5 with R6: capture and overflow on the same edge
    wr(8'hCC, 8'hFD); wr(8'hCD, 8'hFF);
    wr(8'hC8, 8'h0D);
    trig_pin = 1'b0;
    idle(3);
    bwr(3'd2, 1'b0);
    chk_pins(4'b0011, "R6 R5 both interrupts");
    chk_reg(8'hCA, 8'hFF, "R6 capture at top low");
    chk_reg(8'hCB, 8'hFF, "R6 capture at top high");
    chk_reg(8'hCC, 8'h01, "R5 wrapped then counted");
    chk_reg(8'hCD, 8'h00, "R5 wrapped high");
    chk_reg(8'hC8, 8'hC9, "R5 R6 both flags");
    trig_pin = 1'b1; idle(4);

    // R8 trigger disabled
    wr(8'hC8, 8'h01);
    trig_pin = 1'b0; idle(5);
    chk_reg(8'hCA, 8'hFF, "R8 pair unchanged");
    chk_reg(8'hC8, 8'h01, "R8 no trigger flag");
    chk_pins(4'b0000, "R8 no interrupt");
    trig_pin = 1'b1; idle(4);

    // R7 trigger reload
    wr(8'hCA, 8'h02); wr(8'hCB, 8'h01);
    wr(8'hCC, 8'h55); wr(8'hCD, 8'h55);
    wr(8'hC8, 8'h08);
    trig_pin = 1'b0; idle(4);
    chk_reg(8'hCC, 8'h02, "R7 reload low");
    chk_reg(8'hCD, 8'h01, "R7 reload high");
    chk_reg(8'hC8, 8'h48, "R7 trigger flag");
    trig_pin = 1'b1; idle(4);
    wr(8'hC8, 8'h00);

    // R9 receive baud pulses
    wr(8'hCA, 8'hF0); wr(8'hCB, 8'hFF);
    wr(8'hCC, 8'hFE); wr(8'hCD, 8'hFF);
    wr(8'hC8, 8'h25);
    chk_pins(4'b0000, "R9 no tick before overflow");
    chk_pins(4'b0000, "R9 no tick at top");
    chk_pins(4'b1000, "R9 receive tick after overflow");
    chk_pins(4'b0000, "R9 tick lasts one cycle");
    bwr(3'd2, 1'b0);
    chk_reg(8'hCC, 8'hF3, "R9 reloaded despite capture select");
    chk_reg(8'hC8, 8'h21, "R9 no overflow flag");

    // R9 transmit baud pulse
    wr(8'hCC, 8'hFF); wr(8'hCD, 8'hFF);
    wr(8'hC8, 8'h14);
    chk_pins(4'b0000, "R9 tx quiet before overflow");
    chk_pins(4'b0100, "R9 transmit tick");
    bwr(3'd2, 1'b0);
    chk_reg(8'hCC, 8'hF2, "R9 tx reload then count");
    chk_reg(8'hC8, 8'h10, "R9 tx no overflow flag");

    // R9 trigger in baud mode only flags
    wr(8'hCC, 8'h33); wr(8'hCD, 8'h00);
    wr(8'hC8, 8'h39);
    trig_pin = 1'b0; idle(4);
    chk_reg(8'hCC, 8'h33, "R9 trigger no reload");
    chk_reg(8'hCA, 8'hF0, "R9 trigger no capture");
    chk_reg(8'hC8, 8'h79, "R9 trigger flag only");
    trig_pin = 1'b1; idle(4);
    wr(8'hC8, 8'h00);

    // R11 bus write beats increment
    wr(8'hCC, 8'h20); wr(8'hCD, 8'h00);
    wr(8'hC8, 8'h04);
    idle(1);
    wr(8'hCC, 8'h80);
    bwr(3'd2, 1'b0);
    chk_reg(8'hCC, 8'h81, "R11 count write wins");
    chk_reg(8'hCD, 8'h00, "R11 other byte intact");

    // R11 control write beats flag set on overflow
    wr(8'hCC, 8'hFF); wr(8'hCD, 8'hFF);
    wr(8'hC8, 8'h04);
    wr(8'hC8, 8'h00);
    chk_reg(8'hC8, 8'h00, "R11 flag write wins");
    chk_reg(8'hCC, 8'hF0, "R11 reload still happened");
    chk_pins(4'b0000, "R11 no interrupt");

    idle(2);
    finish_run();
  end

endmodule